// File: doc/BRIEF.md
# Dual-Mode Interrupt Vector Controller

This block gathers level-sensitive interrupt requests from peripherals, picks the most urgent one that may currently be served, and presents it to one processor core as an exception request with a fetch address. Each source has a programmable priority and a handler pointer, both held in tables reached through a simple register port. A register holds the upper half of the vector base address. The lower half always reads as zero, so the slot offset lands in the lower half and never carries into the base.

A mode bit chooses how the core is steered. With the bit clear, every request sends the core to the shared external-input slot at offset 0x40 from the base. Software then reads the acknowledge register, which returns the handler pointer of the winning source and marks that source as in service. With the bit set, the block computes a distinct address for each source: base + 0x1000 + 4 × source number. In this mode the core's exception-taken pulse marks the source as in service. A chip with several cores uses one instance per core.

Nesting is tracked by a stack of in-service priority levels. Only a request whose priority is strictly above the top level is forwarded. An end-of-interrupt write pops one level.

Top module: `ivc_top`

## Requirements
- R1: After reset, `excReq` is low, and the base (address 0x00) and mode (address 0x01) registers read as zero. All source priorities reset to 0.
- R2: A write to the base register keeps bits 31:16. A read of it always returns bits 15:0 as zero.
- R3: With the mode bit (bit 0 at address 0x01) equal to 0, `excAddr` equals base + 0x0040 whenever `excReq` is high.
- R4: With the mode bit equal to 1, `excAddr` equals base + 0x1000 + 4 × the number of the selected source.
- R5: The selected source is the requesting source with the highest priority (4-bit values written at address 0x40 + n). Ties go to the lowest source number. A source with priority 0 is never forwarded.
- R6: A read of address 0x02 returns the handler pointer of the selected source, or zero when nothing is forwarded. In mode 0 this read pushes the source's priority as the new in-service level.
- R7: In mode 1, a one-cycle `excTaken` pulse while `excReq` is high pushes the level, and an acknowledge read does not push. In mode 0, `excTaken` does not push.
- R8: A request is forwarded only when its priority is strictly greater than the current in-service level (0 when the stack is empty).
- R9: A write to address 0x03 pops one in-service level. Such a write with an empty stack has no effect.
- R10: The stack holds 8 levels. While it is full, `excReq` stays low.
- R11: The handler pointer of source n is written and read back at address 0x20 + n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 32 | Level requests, one per source |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effect on acknowledge) |
| regAddr | input | 7 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from address |
| excTaken | input | 1 | Core accepted the exception |
| excReq | output | 1 | Exception request to the core |
| excAddr | output | 32 | Fetch address for the exception |

## Verification
The hardest situation to reach is a completely full level stack. Filling it takes eight acceptances in a row, each at a priority strictly above the one before. The bench builds this directly: it raises sources one by one with ascending priorities and accepts each in turn, then adds a still-higher source, which must stay blocked until one level is popped. A seeded random phase then mixes acknowledges, accept pulses, end-of-interrupt writes and mode changes under random request and priority patterns. This drives the stack up and down, and through mode changes while levels are still held.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int REG_AW = 7;
  localparam int OFF_W = 16;
  localparam logic [OFF_W-1:0] EXT_SLOT_OFF = 16'h0040;
  localparam logic [OFF_W-1:0] HW_TABLE_OFF = 16'h1000;

  typedef enum logic [2:0] {
    K_BASE, K_MODE, K_ACK, K_EOI, K_HANDLER, K_PRIO, K_NONE
  } regKind_e;

  typedef struct packed {
    logic baseWr;
    logic modeWr;
    logic handlerWr;
    logic prioWr;
    logic push;
    logic pop;
  } ivcStrobe_t;

  function automatic regKind_e decodeAddr(logic [REG_AW-1:0] a);
    regKind_e k;
    case (a[REG_AW-1:REG_AW-2])
      2'b01: k = K_HANDLER;
      2'b10: k = K_PRIO;
      2'b00: begin
        case (a[REG_AW-3:0])
          5'd0: k = K_BASE;
          5'd1: k = K_MODE;
          5'd2: k = K_ACK;
          5'd3: k = K_EOI;
          default: k = K_NONE;
        endcase
      end
      default: k = K_NONE;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/ivc_ctrl.sv
module ivc_ctrl
  import ivc_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              excTaken,
  input  logic              modeHw,
  input  logic              fwdValid,
  input  logic              depthEmpty,
  output ivcStrobe_t        strobe
);
  regKind_e kind;
  logic acceptEvt;

  always_comb begin
    kind = decodeAddr(regAddr);
    // mode 0 accepts on the acknowledge read, mode 1 on the core handshake
    acceptEvt = modeHw ? excTaken : (regRdEn && kind == K_ACK);
    strobe.baseWr    = regWrEn && kind == K_BASE;
    strobe.modeWr    = regWrEn && kind == K_MODE;
    strobe.handlerWr = regWrEn && kind == K_HANDLER;
    strobe.prioWr    = regWrEn && kind == K_PRIO;
    strobe.pop       = regWrEn && kind == K_EOI && !depthEmpty;
    // a pop in the same cycle wins; the request is accepted later
    strobe.push      = fwdValid && acceptEvt && !strobe.pop;
  end
endmodule

// File: rtl/ivc_datapath.sv
module ivc_datapath
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 32,
  parameter int DEPTH   = 8,
  localparam int SRC_W   = $clog2(NUM_SRC),
  localparam int DEPTH_W = $clog2(DEPTH + 1),
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ivcStrobe_t         strobe,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [ADDR_W-1:0]  regWrData,
  input  logic [NUM_SRC-1:0] irqReq,
  output logic [ADDR_W-1:0]  regRdData,
  output logic               excReq,
  output logic [ADDR_W-1:0]  excAddr,
  output logic               modeHw,
  output logic [DEPTH_W-1:0] depth
);
  logic [ADDR_W-1:OFF_W] baseHi;
  logic [ADDR_W-1:0]     handler [NUM_SRC];
  logic [PRIO_W-1:0]     prio    [NUM_SRC];
  logic [PRIO_W-1:0]     levels  [DEPTH];
  logic [SRC_W-1:0]      regIdx;
  logic [PRIO_W-1:0]     curPrio, winPrio;
  logic [SRC_W-1:0]      winId;
  logic                  winValid;
  logic [OFF_W-1:0]      slotOff;

  assign regIdx = regAddr[SRC_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseHi <= '0;
      modeHw <= 1'b0;
      depth  <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        handler[i] <= '0;
        prio[i]    <= '0;
      end
      for (int j = 0; j < DEPTH; j++) levels[j] <= '0;
    end else begin
      if (strobe.baseWr)    baseHi <= regWrData[ADDR_W-1:OFF_W];
      if (strobe.modeWr)    modeHw <= regWrData[0];
      if (strobe.handlerWr) handler[regIdx] <= regWrData;
      if (strobe.prioWr)    prio[regIdx] <= regWrData[PRIO_W-1:0];
      if (strobe.push) begin
        levels[depth[PTR_W-1:0]] <= winPrio;
        depth <= depth + 1'b1;
      end else if (strobe.pop) begin
        depth <= depth - 1'b1;
      end
    end
  end

  assign curPrio = (depth == '0) ? '0 : levels[PTR_W'(depth - 1'b1)];

  // strict compare against the running winner keeps ties on the lowest index
  always_comb begin
    winValid = 1'b0;
    winId    = '0;
    winPrio  = curPrio;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (irqReq[i] && prio[i] > winPrio) begin
        winValid = 1'b1;
        winId    = SRC_W'(i);
        winPrio  = prio[i];
      end
    end
  end

  assign excReq  = winValid && (depth != DEPTH_W'(DEPTH));
  assign slotOff = modeHw ? HW_TABLE_OFF + OFF_W'({winId, 2'b00}) : EXT_SLOT_OFF;
  assign excAddr = {baseHi, slotOff};

  always_comb begin
    case (decodeAddr(regAddr))
      K_BASE:    regRdData = {baseHi, {OFF_W{1'b0}}};
      K_MODE:    regRdData = ADDR_W'(modeHw);
      K_ACK:     regRdData = excReq ? handler[winId] : '0;
      K_HANDLER: regRdData = handler[regIdx];
      K_PRIO:    regRdData = ADDR_W'(prio[regIdx]);
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/ivc_top.sv
module ivc_top
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 32,
  parameter int DEPTH   = 8,
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [ADDR_W-1:0]  regWrData,
  output logic [ADDR_W-1:0]  regRdData,
  input  logic               excTaken,
  output logic               excReq,
  output logic [ADDR_W-1:0]  excAddr
);
  ivcStrobe_t strobe;
  logic modeHw;
  logic [DEPTH_W-1:0] depth;

  ivc_ctrl u_ctrl (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .excTaken(excTaken), .modeHw(modeHw), .fwdValid(excReq),
    .depthEmpty(depth == '0), .strobe(strobe)
  );

  ivc_datapath #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .regWrData(regWrData), .irqReq(irqReq), .regRdData(regRdData),
    .excReq(excReq), .excAddr(excAddr), .modeHw(modeHw), .depth(depth)
  );
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DEPTH   = 8,
  parameter int DEPTH_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               excReq,
  input logic [ADDR_W-1:0]  excAddr,
  input logic               modeHw,
  input logic               regWrEn,
  input logic [REG_AW-1:0]  regAddr,
  input logic [ADDR_W-1:0]  regRdData,
  input logic               push,
  input logic               pop,
  input logic [DEPTH_W-1:0] depth
);
  AST_SW_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    excReq && !modeHw |-> excAddr[OFF_W-1:0] == 16'h0040); // R3
  AST_HW_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    excReq && modeHw |-> excAddr[OFF_W-1:12] == 4'h1 && excAddr[1:0] == 2'b00); // R4
  AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    decodeAddr(regAddr) == K_BASE |-> regRdData[OFF_W-1:0] == '0); // R2
  AST_PUSH_DEPTH: assert property (@(posedge clk) disable iff (!rstN)
    push |=> depth == DEPTH_W'($past(depth) + 1'b1)); // R8
  AST_POP_DEPTH: assert property (@(posedge clk) disable iff (!rstN)
    pop |=> depth == DEPTH_W'($past(depth) - 1'b1)); // R9
  AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && decodeAddr(regAddr) == K_EOI && depth == '0 |=> depth == '0); // R9
  AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    depth == DEPTH_W'(DEPTH) |-> !excReq); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    depth <= DEPTH_W'(DEPTH)); // R10
endmodule

bind ivc_top ivc_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .DEPTH_W(DEPTH_W)) u_chk (
  .clk(clk), .rstN(rstN), .excReq(excReq), .excAddr(excAddr), .modeHw(modeHw),
  .regWrEn(regWrEn), .regAddr(regAddr), .regRdData(regRdData),
  .push(strobe.push), .pop(strobe.pop), .depth(depth)
);

// File: tb/tb_ivc_top.sv
module tb_ivc_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic [31:0] irqReq = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0, excTaken = 1'b0;
  logic [6:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData, excAddr;
  logic excReq;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [3:0]  mPrio [32];
  logic [31:0] mHandler [32];
  logic [3:0]  mLevels [8];
  int mDepth = 0;
  logic [31:0] mBase = '0;
  bit mMode = 0;

  always #4 clk = ~clk;

  ivc_top dut (.clk(clk), .rstN(rstN), .irqReq(irqReq), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .excTaken(excTaken), .excReq(excReq), .excAddr(excAddr));

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int curLvl();
    return (mDepth == 0) ? 0 : int'(mLevels[mDepth-1]);
  endfunction

  function automatic int expWin(logic [31:0] req);
    int best = curLvl(), id = -1;
    if (mDepth == 8) return -1;
    for (int i = 0; i < 32; i++)
      if (req[i] && int'(mPrio[i]) > best) begin best = int'(mPrio[i]); id = i; end
    return id;
  endfunction

  function automatic logic [31:0] expAddr(int id);
    return mMode ? (mBase + 32'h1000 + 32'(id * 4)) : (mBase + 32'h40);
  endfunction

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(posedge clk); #1 regWrEn = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1; regAddr = a; #1 d = regRdData;
    @(posedge clk); #1 regRdEn = 0;
  endtask

  task automatic setPrio(int i, logic [3:0] p);
    wr(7'h40 + 7'(i), 32'(p)); mPrio[i] = p;
  endtask

  task automatic setMode(bit m);
    wr(7'h01, 32'(m)); mMode = m;
  endtask

  task automatic push(int id);
    mLevels[mDepth] = mPrio[id]; mDepth++;
  endtask

  task automatic checkOut(string tag);
    int w;
    @(negedge clk); #1;
    w = expWin(irqReq);
    check(excReq == (w >= 0), {tag, " excReq"}, 32'(excReq), 32'(w >= 0));
    if (w >= 0) check(excAddr == expAddr(w), {tag, " excAddr"}, excAddr, expAddr(w));
  endtask

  task automatic ack(string tag);
    logic [31:0] d;
    int w = expWin(irqReq);
    rd(7'h02, d);
    check(d == ((w >= 0) ? mHandler[w] : 32'h0), {tag, " ack data"}, d,
          (w >= 0) ? mHandler[w] : 32'h0);
    if (!mMode && w >= 0) push(w);
  endtask

  task automatic take();
    int w = expWin(irqReq);
    @(negedge clk); excTaken = 1;
    @(posedge clk); #1 excTaken = 0;
    if (mMode && w >= 0) push(w);
  endtask

  task automatic eoi();
    wr(7'h03, 32'h0);
    if (mDepth > 0) mDepth--;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 32; i++) begin mPrio[i] = 0; mHandler[i] = 0; end
    repeat (3) @(posedge clk); #1 rstN = 1;

    // R1 reset state
    checkOut("R1");
    rd(7'h00, d); check(d == 0, "R1 base", d, 0);
    rd(7'h01, d); check(d == 0, "R1 mode", d, 0);

    // R2 base low half forced to zero
    wr(7'h00, 32'hDEADBEEF); mBase = 32'hDEAD0000;
    rd(7'h00, d); check(d == 32'hDEAD0000, "R2 base readback", d, 32'hDEAD0000);

    // R11 handler table
    for (int i = 0; i < 32; i++) begin
      mHandler[i] = 32'h1000_0000 + 32'(i) * 32'h10;
      wr(7'h20 + 7'(i), mHandler[i]);
    end
    rd(7'h25, d); check(d == mHandler[5], "R11 handler 5", d, mHandler[5]);
    rd(7'h3F, d); check(d == mHandler[31], "R11 handler 31", d, mHandler[31]);

    // R5 priority 0 masked
    @(negedge clk); irqReq = 32'h8; checkOut("R5 prio0");
    check(excReq == 0, "R5 prio0 masked", 32'(excReq), 0);

    // R5 tie and R3 shared slot
    setPrio(3, 7); setPrio(9, 7); setPrio(20, 2); setPrio(12, 9);
    @(negedge clk); irqReq = (32'h1 << 3) | (32'h1 << 9) | (32'h1 << 20);
    checkOut("R5 tie/R3");
    check(excAddr == 32'hDEAD0040, "R3 slot addr", excAddr, 32'hDEAD0040);

    // R6 ack latches, R8 equal level blocked
    ack("R6");
    checkOut("R8 equal blocked");
    check(excReq == 0, "R8 equal level", 32'(excReq), 0);
    @(negedge clk); irqReq[12] = 1; checkOut("R8 higher");
    check(excReq == 1, "R8 higher passes", 32'(excReq), 1);
    ack("R6 nest");
    // R7 excTaken ignored in mode 0
    eoi(); checkOut("R9 pop");
    take(); checkOut("R7 sw take ignored");
    check(excReq == 1, "R7 sw take", 32'(excReq), 1);

    // R9 pop to empty then extra EOI
    eoi(); eoi(); eoi(); checkOut("R9 empty eoi");
    check(excReq == 1, "R9 empty eoi no effect", 32'(excReq), 1);

    // R4 hardware mode, R7 ack does not latch, take does
    setMode(1); checkOut("R4");
    check(excAddr == 32'hDEAD1030, "R4 addr src12", excAddr, 32'hDEAD1030);
    ack("R7 hw ack"); checkOut("R7 hw ack no push");
    check(excReq == 1, "R7 hw ack no push", 32'(excReq), 1);
    take(); checkOut("R7 hw take");
    check(excReq == 0, "R7 hw take push", 32'(excReq), 0);
    eoi();

    // R10 full stack
    @(negedge clk); irqReq = 0;
    for (int i = 0; i < 9; i++) setPrio(i, 4'(i + 1));
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); irqReq[i] = 1; checkOut("R10 fill"); take();
    end
    @(negedge clk); irqReq[8] = 1; checkOut("R10 full");
    check(excReq == 0, "R10 full blocks", 32'(excReq), 0);
    eoi(); checkOut("R10 after pop");
    check(excReq == 1 && excAddr == 32'hDEAD1020, "R10 reopen", excAddr, 32'hDEAD1020);
    repeat (9) eoi();

    // random phase
    for (int i = 0; i < 32; i++) setPrio(i, 4'($urandom));
    for (int n = 0; n < 400; n++) begin
      @(negedge clk); irqReq = $urandom;
      checkOut("R5 random");
      case ($urandom % 5)
        0: ack("R6 random");
        1: take();
        2, 3: eoi();
        default: setMode(1'($urandom));
      endcase
    end
    checkOut("R8 random end");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule